// File: doc/BRIEF.md
# Register-Pattern Read Burst Generator

This block is the memory-side answer path used while the device is in its register-read mode. A read command arrives with three low column bits, a per-command chop bit and a burst-length policy. After a programmable read latency, the block plays out a short burst taken from an 8-bit pattern register, one bit per beat. Each beat's bit is copied onto every data line of the device, so the controller can read the pattern from any lane while it trains its capture timing.

Commands come in over a valid/ready handshake. `cmd_ready` falls for the rest of a burst's slot after a good command is taken, so that back-to-back commands produce a gap-free data stream and never overlap. The upstream side must hold `cmd_valid` and its fields until `cmd_ready` is seen high at a rising edge. The data side has no back-pressure, because the read latency is fixed by protocol. `dq_valid` simply marks the beats. A command that breaks the protocol is consumed and produces no data, and it sets a sticky error flag. The model is single data rate: one beat per rising clock edge.

Top module: `mpr_burst_gen`

## Requirements
- R1: During every beat, all `DQ_W` data lines carry the same bit. With `DQ_W`=16 this covers both byte lanes.
- R2: A full burst (8 beats) plays `pattern[0]`, `pattern[1]`, … `pattern[7]` in that order, bit 0 being the LSB.
- R3: A chopped burst (4 beats) with `col_lo[2]`=0 plays pattern bits 0,1,2,3. With `col_lo[2]`=1 it plays bits 4,5,6,7.
- R4: `bl_mode` selects the burst length: 2'b00 always 8 beats, 2'b10 always 4 beats, 2'b01 per command (`bc_n`=0 gives 4, `bc_n`=1 gives 8), and 2'b11 behaves as 2'b00.
- R5: If a command is taken at rising edge k, the first beat is visible after edge k+L and `dq_valid` is low after edge k+L-1. L is `rd_lat` clamped into 5..16.
- R6: A command taken while `dll_locked` is low drives no beat and sets `proto_err`.
- R7: A command with `col_lo[1:0]` other than 2'b00, or with `col_lo[2]`=1 on an 8-beat burst, drives no beat and sets `proto_err`. `col_lo[2]`=1 on a 4-beat burst is legal.
- R8: `proto_err` stays high until reset, including across later legal commands.
- R9: `dq_valid` is high for exactly 4 or 8 consecutive cycles per command. `dq` is all zero whenever `dq_valid` is low.
- R10: After a legal command is taken, `cmd_ready` is low for burst-length minus one cycles. A command held during that time is taken on the first edge where the slot is free, and its beats follow the previous burst with no gap.
- R11: The pattern is captured when the command is taken. Changes to `pattern` afterwards do not alter that burst.
- R12: Out of reset, `dq_valid`=0, `dq`=0, `proto_err`=0 and `cmd_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock, one beat per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Read command present |
| cmd_ready | output | 1 | Command slot free; a command is taken when both are high |
| col_lo | input | 3 | Column bits 2..0 of the command |
| bc_n | input | 1 | Per-command chop select, low means 4 beats |
| bl_mode | input | 2 | Burst-length policy (see R4) |
| rd_lat | input | 5 | Read latency in cycles, clamped to 5..16; hold constant while bursts are pending |
| dll_locked | input | 1 | Clock-alignment loop is locked |
| pattern | input | 8 | Predefined pattern register |
| dq | output | DQ_W | Beat bit replicated on every data line |
| dq_valid | output | 1 | Beat present on `dq` |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest case to reach is two legal commands meeting at the slot boundary. The second command is held on the handshake while `cmd_ready` is low, and it must be taken on exactly the edge that lets its first beat land right after the previous burst's last beat. The bench reaches this by keeping `cmd_valid` high straight after a full burst is accepted. It then tracks `cmd_ready` on each cycle and checks all sixteen beats as one unbroken stream built from two different patterns. A pattern change while a burst is still in the latency pipeline is forced the same way, right after acceptance.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

  localparam int PAT_W = 8;

  typedef enum logic [1:0] {
    BLM_FIXED8 = 2'b00,
    BLM_OTF    = 2'b01,
    BLM_FIXED4 = 2'b10,
    BLM_RSVD   = 2'b11
  } blmode_e;

  typedef struct packed {
    logic             vld;
    logic             chop;
    logic             upper;
    logic [PAT_W-1:0] pat;
  } slot_t;

endpackage

// File: rtl/mpr_cmd_decode.sv
module mpr_cmd_decode
  import mpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       col_lo,
  input  logic             bc_n,
  input  logic [1:0]       bl_mode,
  input  logic             dll_locked,
  input  logic [PAT_W-1:0] pattern,
  output slot_t            push_slot,
  output logic             proto_err
);

  localparam logic [2:0] GAP4 = 3'd3;
  localparam logic [2:0] GAP8 = 3'd7;

  blmode_e    mode;
  logic       chop;
  logic       bad;
  logic       take;
  logic [2:0] gap_q;
  logic       err_q;

  assign mode = blmode_e'(bl_mode);

  always_comb begin
    case (mode)
      BLM_FIXED4: chop = 1'b1;
      BLM_OTF:    chop = ~bc_n;
      default:    chop = 1'b0;
    endcase
  end

  assign bad  = ~dll_locked | (col_lo[1:0] != 2'b00) | (~chop & col_lo[2]);
  assign take = cmd_valid & cmd_ready;

  assign push_slot.vld   = take & ~bad;
  assign push_slot.chop  = chop;
  assign push_slot.upper = col_lo[2];
  assign push_slot.pat   = pattern;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (take && !bad)      gap_q <= chop ? GAP4 : GAP8;
      else if (gap_q != '0)  gap_q <= gap_q - 3'd1;
      if (take && bad)       err_q <= 1'b1;
    end
  end

  assign cmd_ready = (gap_q == '0);
  assign proto_err = err_q;

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_gap_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !bad) |=> !cmd_ready);

endmodule

// File: rtl/mpr_lat_pipe.sv
module mpr_lat_pipe
  import mpr_pkg::*;
#(
  parameter int LAT_MAX = 16,
  parameter int LAT_MIN = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  slot_t                        in_slot,
  input  logic [$clog2(LAT_MAX+1)-1:0] rd_lat,
  output slot_t                        head,
  output slot_t                        tap
);

  localparam int LAT_W = $clog2(LAT_MAX + 1);
  localparam int IDX_W = $clog2(LAT_MAX);

  slot_t            stage [LAT_MAX];
  logic [LAT_W-1:0] lat_c;
  logic [LAT_W-1:0] lat_m1;

  always_comb begin
    if (rd_lat < LAT_W'(LAT_MIN))      lat_c = LAT_W'(LAT_MIN);
    else if (rd_lat > LAT_W'(LAT_MAX)) lat_c = LAT_W'(LAT_MAX);
    else                               lat_c = rd_lat;
  end

  assign lat_m1 = lat_c - LAT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= in_slot;
  end

  for (genvar s = 1; s < LAT_MAX; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign head = stage[0];
  assign tap  = stage[lat_m1[IDX_W-1:0]];

endmodule

// File: rtl/mpr_beat_engine.sv
module mpr_beat_engine
  import mpr_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  slot_t           tap,
  output logic [DQ_W-1:0] dq,
  output logic            dq_valid
);

  localparam int HALF  = PAT_W / 2;
  localparam int CNT_W = $clog2(PAT_W + 1);

  logic [PAT_W-1:0] sr_q;
  logic [CNT_W-1:0] left_q;
  logic             beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      left_q <= '0;
    end else if (tap.vld) begin
      sr_q   <= tap.upper ? {{HALF{1'b0}}, tap.pat[PAT_W-1:HALF]} : tap.pat;
      left_q <= tap.chop ? CNT_W'(HALF) : CNT_W'(PAT_W);
    end else if (left_q != '0) begin
      sr_q   <= sr_q >> 1;
      left_q <= left_q - CNT_W'(1);
    end
  end

  assign dq_valid = (left_q != '0);
  assign beat     = sr_q[0] & dq_valid;

  for (genvar g = 0; g < DQ_W; g++) begin : g_lane
    assign dq[g] = beat;
  end

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tap.vld |-> (left_q <= CNT_W'(1)));

  assert_load_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tap.vld |=> dq_valid);

endmodule

// File: rtl/mpr_burst_gen.sv
module mpr_burst_gen
  import mpr_pkg::*;
#(
  parameter int DQ_W    = 16,
  parameter int LAT_MAX = 16,
  parameter int LAT_MIN = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [2:0]                   col_lo,
  input  logic                         bc_n,
  input  logic [1:0]                   bl_mode,
  input  logic [$clog2(LAT_MAX+1)-1:0] rd_lat,
  input  logic                         dll_locked,
  input  logic [7:0]                   pattern,
  output logic [DQ_W-1:0]              dq,
  output logic                         dq_valid,
  output logic                         proto_err
);

  slot_t push_slot;
  slot_t head;
  slot_t tap;

  mpr_cmd_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .col_lo     (col_lo),
    .bc_n       (bc_n),
    .bl_mode    (bl_mode),
    .dll_locked (dll_locked),
    .pattern    (pattern),
    .push_slot  (push_slot),
    .proto_err  (proto_err)
  );

  mpr_lat_pipe #(.LAT_MAX(LAT_MAX), .LAT_MIN(LAT_MIN)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_slot (push_slot),
    .rd_lat  (rd_lat),
    .head    (head),
    .tap     (tap)
  );

  mpr_beat_engine #(.DQ_W(DQ_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .tap      (tap),
    .dq       (dq),
    .dq_valid (dq_valid)
  );

  assert_unlocked_no_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !dll_locked) |=> !head.vld);

  assert_bad_addr_no_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (col_lo[1:0] != 2'b00)) |=> !head.vld);

endmodule

// File: tb/sim_mpr_burst_gen.sv
module sim_mpr_burst_gen;

  localparam int DQ_W = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cmd_valid;
  logic            cmd_ready;
  logic [2:0]      col_lo;
  logic            bc_n;
  logic [1:0]      bl_mode;
  logic [4:0]      rd_lat;
  logic            dll_locked;
  logic [7:0]      pattern;
  logic [DQ_W-1:0] dq;
  logic            dq_valid;
  logic            proto_err;

  int vectors = 0;
  int errors  = 0;

  always #4 clk = ~clk;

  mpr_burst_gen #(.DQ_W(DQ_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .col_lo(col_lo), .bc_n(bc_n), .bl_mode(bl_mode), .rd_lat(rd_lat),
    .dll_locked(dll_locked), .pattern(pattern), .dq(dq), .dq_valid(dq_valid),
    .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drives one command; returns at the negedge right after the accepting edge.
  task automatic issue(input logic [2:0] col, input logic bcn, input logic [1:0] mode,
                       input logic [7:0] pat, input logic dll);
    @(negedge clk);
    col_lo = col; bc_n = bcn; bl_mode = mode; pattern = pat; dll_locked = dll;
    cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_burst(input string req, input int lat, input logic [7:0] pat,
                              input int len, input bit upper);
    repeat (lat - 1) @(negedge clk);
    chk({req, " R5 early"}, dq_valid, 1'b0);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk({req, " R9 valid"}, dq_valid, 1'b1);
      chk({req, " R1 lanes"}, dq, {DQ_W{pat[(upper ? 4 : 0) + i]}});
    end
    @(negedge clk);
    chk({req, " R9 end"}, dq_valid, 1'b0);
    chk({req, " R9 idle"}, dq, '0);
  endtask

  task automatic expect_silence(input string req, input int cycles);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (dq_valid) seen = 1'b1;
    end
    chk({req, " no data"}, seen, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 dq_valid", dq_valid, 1'b0);
    chk("R12 dq", dq, '0);
    chk("R12 proto_err", proto_err, 1'b0);
    chk("R12 cmd_ready", cmd_ready, 1'b1);
  endtask

  task automatic t_full_bursts();
    rd_lat = 5'd5;
    issue(3'b000, 1'b1, 2'b00, 8'hA5, 1'b1);
    expect_burst("R2 A5", 5, 8'hA5, 8, 1'b0);
    rd_lat = 5'd9;
    issue(3'b000, 1'b1, 2'b00, 8'h3C, 1'b1);
    expect_burst("R2 3C", 9, 8'h3C, 8, 1'b0);
  endtask

  task automatic t_chop();
    rd_lat = 5'd6;
    issue(3'b000, 1'b1, 2'b10, 8'hB4, 1'b1);
    expect_burst("R3 low", 6, 8'hB4, 4, 1'b0);
    issue(3'b100, 1'b1, 2'b10, 8'hB4, 1'b1);
    expect_burst("R3 high", 6, 8'hB4, 4, 1'b1);
  endtask

  task automatic t_modes();
    rd_lat = 5'd7;
    issue(3'b100, 1'b0, 2'b01, 8'h96, 1'b1);
    expect_burst("R4 otf chop", 7, 8'h96, 4, 1'b1);
    issue(3'b000, 1'b1, 2'b01, 8'h69, 1'b1);
    expect_burst("R4 otf full", 7, 8'h69, 8, 1'b0);
    issue(3'b000, 1'b0, 2'b11, 8'hC3, 1'b1);
    expect_burst("R4 rsvd full", 7, 8'hC3, 8, 1'b0);
    issue(3'b000, 1'b0, 2'b00, 8'h5A, 1'b1);
    expect_burst("R4 fixed ignores bc", 7, 8'h5A, 8, 1'b0);
  endtask

  task automatic t_clamp();
    rd_lat = 5'd2;
    issue(3'b000, 1'b1, 2'b00, 8'h81, 1'b1);
    expect_burst("R5 clamp low", 5, 8'h81, 8, 1'b0);
    rd_lat = 5'd20;
    issue(3'b000, 1'b1, 2'b00, 8'h7E, 1'b1);
    expect_burst("R5 clamp high", 16, 8'h7E, 8, 1'b0);
  endtask

  task automatic t_pattern_hold();
    rd_lat = 5'd8;
    issue(3'b000, 1'b1, 2'b00, 8'hE1, 1'b1);
    pattern = 8'h1E;
    expect_burst("R11 captured", 8, 8'hE1, 8, 1'b0);
  endtask

  task automatic t_back_to_back();
    logic [15:0] stream;
    rd_lat = 5'd6;
    stream = {8'h4D, 8'hB2};
    issue(3'b000, 1'b1, 2'b00, 8'hB2, 1'b1);
    pattern = 8'h4D;
    cmd_valid = 1'b1;
    // negedge n sees state after edge k+n-1
    for (int n = 1; n <= 6 + 18; n++) begin
      if (n > 1) @(negedge clk);
      if (n <= 8) chk("R10 ready gap", cmd_ready, (n == 8) ? 1'b1 : 1'b0);
      if (n == 9) begin
        cmd_valid = 1'b0;
        pattern   = 8'h00;
        chk("R10 second taken", cmd_ready, 1'b0);
      end
      if (n >= 7 && n <= 22) begin
        chk("R10 contiguous", dq_valid, 1'b1);
        chk("R10 R1 stream", dq, {DQ_W{stream[n - 7]}});
      end else begin
        chk("R9 outside", dq_valid, 1'b0);
      end
    end
  endtask

  task automatic t_err_dll();
    do_reset();
    rd_lat = 5'd5;
    issue(3'b000, 1'b1, 2'b00, 8'hFF, 1'b0);
    chk("R6 err set", proto_err, 1'b1);
    expect_silence("R6 unlocked", 20);
    issue(3'b000, 1'b1, 2'b00, 8'h0F, 1'b1);
    expect_burst("R8 data after err", 5, 8'h0F, 8, 1'b0);
    chk("R8 still set", proto_err, 1'b1);
  endtask

  task automatic t_err_addr();
    do_reset();
    rd_lat = 5'd5;
    issue(3'b001, 1'b1, 2'b00, 8'hFF, 1'b1);
    chk("R7 low bits err", proto_err, 1'b1);
    expect_silence("R7 low bits", 20);
    do_reset();
    issue(3'b100, 1'b1, 2'b00, 8'hFF, 1'b1);
    chk("R7 upper on full err", proto_err, 1'b1);
    expect_silence("R7 upper on full", 20);
    do_reset();
    issue(3'b100, 1'b1, 2'b10, 8'hF0, 1'b1);
    chk("R7 upper on chop legal", proto_err, 1'b0);
    expect_burst("R7 upper chop data", 5, 8'hF0, 4, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; col_lo = '0; bc_n = 1'b1;
    bl_mode = 2'b00; rd_lat = 5'd5; dll_locked = 1'b1; pattern = '0;
    t_reset();
    t_full_bursts();
    t_chop();
    t_modes();
    t_clamp();
    t_pattern_hold();
    t_back_to_back();
    t_err_dll();
    t_err_addr();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule